// File: doc/BRIEF.md
# Low-Power Real-Time Counter with Power-Off Request

This block is a small register file that keeps a free-running 47-bit time counter and a 32-bit control word, and turns one specific control write into a power-off request. The counter advances once for every cycle in which the time-base enable is high. In normal use that enable comes from a 32768 Hz tick, so the low 15 bits count fractions of a second and the bits above them count whole seconds.

Software uses a plain 32-bit register bus with a 12-bit byte address, a write strobe, a read strobe and write data. Read data is registered: it appears one cycle after the read strobe and holds until the next read. Software reads the counter as two words: a 15-bit upper word and a 32-bit lower word. A write to either word replaces that part of the live count and leaves the other part as it is. When a write to the control word sets the turn-off bit and the power-down-enable bit together, the block pulses its power-off request output for one cycle.

Top module: `rtc_pwroff_regs`

## Requirements
- R1: In each cycle where `tick_en` is 1 and no counter word is written, the 47-bit counter increases by exactly one. A carry from bit 31 passes into bit 32, and the all-ones value wraps to zero. When there is no tick and no counter write, the counter holds its value.
- R2: A read at offset 0x50 returns counter bits 46:32 in rdata[14:0], with rdata[31:15] zero.
- R3: A read at offset 0x54 returns counter bits 31:0.
- R4: A write at offset 0x54 loads counter bits 31:0 from wdata and leaves bits 46:32 unchanged.
- R5: A write at offset 0x50 loads counter bits 46:32 from wdata[14:0] and leaves bits 31:0 unchanged. wdata[31:15] is discarded.
- R6: When a counter write and `tick_en` fall in the same cycle, the written value is loaded without an increment. Ticks count again from the following cycle.
- R7: A write at offset 0x38 stores all 32 bits of wdata into the control word, and a read at 0x38 returns it unchanged. The control word keeps its value when it is not written.
- R8: `pwroff_req` is 1 for exactly the one cycle after a control write in which wdata[6] (turn-off) and wdata[5] (power-down enable) are both 1. It is 1 at no other time, and every such write produces its own pulse.
- R9: While reset is asserted, the control word, the counter, `rdata` and `pwroff_req` are all zero.
- R10: Reads of aligned offsets other than 0x38, 0x50 and 0x54 return zero, and writes to them change nothing. Any access with addr[1:0] not equal to 0 is ignored: such a read returns zero and such a write has no effect.
- R11: `rdata` is loaded on the clock edge where `rd_en` is 1 and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Time-base enable, one cycle per count step |
| addr | input | 12 | Byte offset within the 4 KB register window |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pwroff_req | output | 1 | One-cycle power-off request |

## Verification
The hardest case to reach from the ports is a word write landing in the same cycle as a tick. In that cycle a priority mistake would show up as either a lost write or an extra increment. The bench holds `tick_en` low except at chosen edges, so the count is always known exactly. It then raises the tick in the same cycle as a lower-word write, and separately as an upper-word write, and reads both words back. Carries are reached by loading values next to the 32-bit boundary and the 47-bit wrap point and then applying a known number of ticks. A full sweep of every aligned offset covers the decoder.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;

    typedef struct packed {
        logic ctrl;
        logic hi;
        logic lo;
    } sel_t;
endpackage

// File: rtl/rtc_decode.sv
module rtc_decode
    import rtc_pkg::*;
#(
    parameter logic [ADDR_W-1:0] OFF_CTRL = 12'h038,
    parameter logic [ADDR_W-1:0] OFF_HI   = 12'h050,
    parameter logic [ADDR_W-1:0] OFF_LO   = 12'h054
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_t              sel
);
    logic aligned;

    always_comb begin
        aligned  = (addr[1:0] == 2'b00);
        sel.ctrl = aligned && (addr == OFF_CTRL);
        sel.hi   = aligned && (addr == OFF_HI);
        sel.lo   = aligned && (addr == OFF_LO);
    end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
    parameter int unsigned HI_W = 15,
    parameter int unsigned LO_W = 32,
    localparam int unsigned CNT_W = HI_W + LO_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_hi,
    input  logic             wr_lo,
    input  logic [HI_W-1:0]  hi_data,
    input  logic [LO_W-1:0]  lo_data,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_hi) begin
            st_d.cnt[CNT_W-1:LO_W] = hi_data;
        end else if (wr_lo) begin
            st_d.cnt[LO_W-1:0] = lo_data;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned OFF_BIT  = 6,
    parameter int unsigned PDEN_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl,
    output logic              req
);
    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic              req;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = wr && wdata[OFF_BIT] && wdata[PDEN_BIT];
        if (wr) st_d.ctrl = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl = st_q.ctrl;
    assign req  = st_q.req;
endmodule

// File: rtl/rtc_pwroff_regs.sv
module rtc_pwroff_regs
    import rtc_pkg::*;
#(
    parameter int unsigned       HI_W     = 15,
    parameter logic [ADDR_W-1:0] OFF_CTRL = 12'h038,
    parameter logic [ADDR_W-1:0] OFF_HI   = 12'h050,
    parameter logic [ADDR_W-1:0] OFF_LO   = 12'h054,
    parameter int unsigned       OFF_BIT  = 6,
    parameter int unsigned       PDEN_BIT = 5,
    localparam int unsigned      LO_W     = DATA_W,
    localparam int unsigned      CNT_W    = HI_W + LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              pwroff_req
);
    sel_t              sel;
    logic [CNT_W-1:0]  count_w;
    logic [DATA_W-1:0] ctrl_w;
    logic [DATA_W-1:0] rdata_d, rdata_q;

    rtc_decode #(
        .OFF_CTRL (OFF_CTRL),
        .OFF_HI   (OFF_HI),
        .OFF_LO   (OFF_LO)
    ) u_decode (
        .addr (addr),
        .sel  (sel)
    );

    rtc_counter #(
        .HI_W (HI_W),
        .LO_W (LO_W)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_en),
        .wr_hi   (wr_en && sel.hi),
        .wr_lo   (wr_en && sel.lo),
        .hi_data (wdata[HI_W-1:0]),
        .lo_data (wdata[LO_W-1:0]),
        .count   (count_w)
    );

    rtc_ctrl #(
        .DATA_W   (DATA_W),
        .OFF_BIT  (OFF_BIT),
        .PDEN_BIT (PDEN_BIT)
    ) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_en && sel.ctrl),
        .wdata (wdata),
        .ctrl  (ctrl_w),
        .req   (pwroff_req)
    );

    always_comb begin
        rdata_d = rdata_q;
        if (rd_en) begin
            if (sel.ctrl)    rdata_d = ctrl_w;
            else if (sel.hi) rdata_d = {{(DATA_W-HI_W){1'b0}}, count_w[CNT_W-1:LO_W]};
            else if (sel.lo) rdata_d = count_w[LO_W-1:0];
            else             rdata_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/rtc_pwroff_chk.sv
module rtc_pwroff_chk
    import rtc_pkg::*;
#(
    parameter int unsigned       HI_W     = 15,
    parameter logic [ADDR_W-1:0] OFF_CTRL = 12'h038,
    parameter logic [ADDR_W-1:0] OFF_HI   = 12'h050,
    parameter logic [ADDR_W-1:0] OFF_LO   = 12'h054,
    parameter int unsigned       OFF_BIT  = 6,
    parameter int unsigned       PDEN_BIT = 5,
    localparam int unsigned      CNT_W    = HI_W + DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              pwroff_req,
    input logic [CNT_W-1:0]  count_w,
    input logic [DATA_W-1:0] ctrl_w
);
    logic cnt_wr, ctrl_wr, kill_wr, mapped;
    always_comb begin
        cnt_wr  = wr_en && (addr == OFF_HI || addr == OFF_LO);
        ctrl_wr = wr_en && (addr == OFF_CTRL);
        kill_wr = ctrl_wr && wdata[OFF_BIT] && wdata[PDEN_BIT];
        mapped  = (addr == OFF_CTRL) || (addr == OFF_HI) || (addr == OFF_LO);
    end

    p_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !cnt_wr) |=> (count_w == CNT_W'($past(count_w) + CNT_W'(1))));
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !cnt_wr) |=> $stable(count_w));
    p_write_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_LO) |=> (count_w[DATA_W-1:0] == $past(wdata))
            && (count_w[CNT_W-1:DATA_W] == $past(count_w[CNT_W-1:DATA_W])));
    p_write_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_HI) |=> (count_w[CNT_W-1:DATA_W] == $past(wdata[HI_W-1:0]))
            && (count_w[DATA_W-1:0] == $past(count_w[DATA_W-1:0])));
    p_ctrl_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (ctrl_w == $past(wdata)));
    p_ctrl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(ctrl_w));
    p_pulse_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pwroff_req |-> $past(kill_wr));
    p_pulse_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        kill_wr |=> pwroff_req);
    p_rd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !mapped) |=> (rdata == '0));
    p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

bind rtc_pwroff_regs rtc_pwroff_chk #(
    .HI_W     (HI_W),
    .OFF_CTRL (OFF_CTRL),
    .OFF_HI   (OFF_HI),
    .OFF_LO   (OFF_LO),
    .OFF_BIT  (OFF_BIT),
    .PDEN_BIT (PDEN_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .addr       (addr),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .wdata      (wdata),
    .rdata      (rdata),
    .pwroff_req (pwroff_req),
    .count_w    (count_w),
    .ctrl_w     (ctrl_w)
);

// File: tb/tb_rtc_pwroff_regs.sv
module tb_rtc_pwroff_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        pwroff_req;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [11:0] A_CTRL = 12'h038;
    localparam logic [11:0] A_HI   = 12'h050;
    localparam logic [11:0] A_LO   = 12'h054;

    always #2 clk = ~clk;

    rtc_pwroff_regs dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .addr       (addr),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .wdata      (wdata),
        .rdata      (rdata),
        .pwroff_req (pwroff_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d,
                      output logic p0, output logic p1);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0; p0 = pwroff_req;
        @(negedge clk); p1 = pwroff_req;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic chk_cnt(input string req, input logic [14:0] hi, input logic [31:0] lo);
        logic [31:0] v;
        rd(A_HI, v); chk(req, v, {17'b0, hi});
        rd(A_LO, v); chk(req, v, lo);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic p0, p1;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 rdata in reset", rdata, 32'h0);
        chk("R9 pwroff in reset", {31'b0, pwroff_req}, 32'h0);
        rst_n = 1'b1;
        rd(A_CTRL, v); chk("R9 ctrl after reset", v, 32'h0);
        chk_cnt("R9 counter after reset", 15'h0, 32'h0);

        // R7 R8: every combination of turn-off (bit 6) and enable (bit 5)
        for (int i = 0; i < 4; i++) begin
            logic [31:0] d;
            d = 32'h1234_5690 | (i[0] ? 32'h20 : 32'h0) | (i[1] ? 32'h40 : 32'h0);
            wr(A_CTRL, d, p0, p1);
            chk("R8 pulse after ctrl write", {31'b0, p0}, {31'b0, i == 3});
            chk("R8 pulse lasts one cycle", {31'b0, p1}, 32'h0);
            rd(A_CTRL, v); chk("R7 ctrl readback", v, d);
        end
        wr(A_CTRL, 32'hFFFF_FFFF, p0, p1);
        chk("R8 repeat pulse", {31'b0, p0}, 32'h1);
        rd(A_CTRL, v); chk("R7 ctrl all ones", v, 32'hFFFF_FFFF);

        // R10: misaligned accesses ignored
        wr(A_CTRL | 12'h002, 32'h0000_0060, p0, p1);
        chk("R10 misaligned write no pulse", {31'b0, p0}, 32'h0);
        rd(A_CTRL, v); chk("R10 misaligned write ignored", v, 32'hFFFF_FFFF);
        rd(A_HI | 12'h001, v); chk("R10 misaligned read zero", v, 32'h0);

        // R2 R3 R4 R5: walking bits through both words
        for (int k = 0; k < 32; k++) begin
            wr(A_LO, 32'h1 << k, p0, p1);
            rd(A_LO, v); chk("R3 R4 low walk", v, 32'h1 << k);
        end
        for (int k = 0; k < 15; k++) begin
            wr(A_HI, 32'h1 << k, p0, p1);
            rd(A_HI, v); chk("R2 R5 high walk", v, 32'h1 << k);
        end
        wr(A_LO, 32'hCAFE_0001, p0, p1);
        wr(A_HI, 32'hFFFF_8005, p0, p1);
        chk_cnt("R5 upper wdata dropped, low kept", 15'h0005, 32'hCAFE_0001);
        wr(A_LO, 32'h0BAD_F00D, p0, p1);
        chk_cnt("R4 high kept", 15'h0005, 32'h0BAD_F00D);

        // R1: counting, carry and wrap
        ticks(5);
        chk_cnt("R1 five ticks", 15'h0005, 32'h0BAD_F012);
        wr(A_HI, 32'h3, p0, p1);
        wr(A_LO, 32'hFFFF_FFFE, p0, p1);
        ticks(3);
        chk_cnt("R1 carry into high", 15'h0004, 32'h0000_0001);
        wr(A_HI, 32'h7FFF, p0, p1);
        wr(A_LO, 32'hFFFF_FFFF, p0, p1);
        ticks(1);
        chk_cnt("R1 full wrap", 15'h0000, 32'h0000_0000);
        repeat (10) @(negedge clk);
        chk_cnt("R1 hold without tick", 15'h0000, 32'h0000_0000);

        // R6: write and tick in the same cycle
        @(negedge clk); addr = A_LO; wdata = 32'h0000_1000; wr_en = 1'b1; tick_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        @(negedge clk); tick_en = 1'b0;
        chk_cnt("R6 low write wins then one tick", 15'h0000, 32'h0000_1001);
        @(negedge clk); addr = A_HI; wdata = 32'h0000_0022; wr_en = 1'b1; tick_en = 1'b1;
        @(negedge clk); wr_en = 1'b0; tick_en = 1'b0;
        chk_cnt("R6 high write wins, no increment", 15'h0022, 32'h0000_1001);

        // R10 R11: full aligned sweep of the window
        wr(A_CTRL, 32'h00C0_FFEE, p0, p1);
        wr(12'h040, 32'hFFFF_FFFF, p0, p1);
        chk("R10 unmapped write no pulse", {31'b0, p0}, 32'h0);
        for (int o = 0; o < 4096; o += 4) begin
            logic [31:0] e;
            e = (o == 12'h038) ? 32'h00C0_FFEE :
                (o == 12'h050) ? 32'h0000_0022 :
                (o == 12'h054) ? 32'h0000_1001 : 32'h0;
            rd(12'(o), v); chk("R10 address sweep", v, e);
        end
        repeat (4) @(negedge clk);
        chk("R11 rdata holds without read", rdata, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule